// File: doc/BRIEF.md
# Event Timer Register Interface

This block is the memory-mapped register front end of an event timer with a parameterised number of comparator channels (8 by default, legal range 3 to 32) and a 32-bit main counter. It decodes 4-byte and 8-byte register accesses and answers reads one cycle later. It holds the general configuration and the interrupt status. It owns the main counter, which advances on a tick-enable input standing in for the 2^24 Hz time base. It stores each channel's configuration, comparator and message-route words and presents them to a separate comparator block, along with one-cycle write strobes, a re-arm pulse and status-clear requests.

The counter is governed by a two-state machine. In HALT the counter value is frozen. In RUN it increments once per tick. The transition START (HALT to RUN) happens when a configuration write sets the enable bit. The transition STOP (RUN to HALT) happens when a configuration write clears it. START resumes from the held value and pulses the re-arm output so that the channel timers restart from that value. A counter write made while in RUN also pulses re-arm.

Top module: `evt_timer_regs`

## Requirements
- R1: An access is legal only when req_size is 4 or 8 (bytes) and the address is a multiple of that size. An illegal write changes no register and raises no strobe, re-arm or clear. An illegal read returns 0.
- R2: A 4-byte access with address bit 2 set addresses bits 63:32 of the 64-bit register. A read returns those bits in rsp_rdata[31:0]. A write changes only those bits. A 4-byte access with bit 2 clear reads and writes bits 31:0. Every 4-byte read returns 0 in rsp_rdata[63:32].
- R3: Offset 0x000 reads a fixed capability word: bits 7:0 = 0x01, bits 12:8 = channel count minus 1, bit 13 = 0 (32-bit counter), bits 15:14 = 0, bits 31:16 = 0x8086, and bits 63:32 = 59604644 (the tick period in femtoseconds).
- R4: Offset 0x010 is general configuration. Bit 0 is the counter enable. Bit 1 always reads 0, whatever is written. All other bits store what is written.
- R5: In HALT the main counter holds its value on every cycle without a counter write, whatever tick_en does.
- R6: In RUN, each cycle with tick_en high adds 1 to the counter (modulo 2^32), visible on cnt_value the next cycle. START resumes counting from the held value.
- R7: Offset 0x0F0 is the main counter, zero-extended to 64 bits. A write merges the written lanes into the counter; writes to the upper half have no effect. rearm pulses for one cycle after a START and after a counter write made in RUN, and at no other time.
- R8: Offset 0x020 is interrupt status, with bit n for channel n. A high lvl_set[n] sets bit n. A write clears exactly the bits that are written 1 and are currently set. One cycle later sts_clr pulses for those bits and irq_level shows them low.
- R9: Channel n has its configuration at 0x100+0x20*n, its 32-bit comparator at +0x08 and its 64-bit message route at +0x10. After reset the comparators read 0xFFFFFFFF and the other channel words read 0. A legal write pulses the matching chan_wr_* bit for one cycle, together with the new value on the channel bus.
- R10: A legal read of an offset that maps to no register returns 0.
- R11: rsp_valid is high for exactly one cycle, the cycle after each read request. rsp_rdata reflects register state at the request edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| tick_en | input | 1 | Counter time-base tick |
| req_valid | input | 1 | Access request |
| req_write | input | 1 | 1 = write, 0 = read |
| req_addr | input | ADDR_W | Byte offset |
| req_size | input | 4 | Access size in bytes |
| req_wdata | input | 64 | Write data (4-byte data in bits 31:0) |
| rsp_valid | output | 1 | Read data valid |
| rsp_rdata | output | 64 | Read data |
| cnt_value | output | 32 | Main counter |
| counting | output | 1 | State machine in RUN |
| rearm | output | 1 | Restart all channel timers |
| lvl_set | input | N_CH | Level interrupt set requests |
| irq_level | output | N_CH | Level interrupt lines |
| sts_clr | output | N_CH | Status-clear requests |
| chan_cfg | output | N_CH*64 | Channel configuration words |
| chan_cmp | output | N_CH*32 | Channel comparators |
| chan_route | output | N_CH*64 | Channel message routes |
| chan_wr_cfg | output | N_CH | Configuration write strobes |
| chan_wr_cmp | output | N_CH | Comparator write strobes |
| chan_wr_route | output | N_CH | Route write strobes |

## Verification
If the run state is wrong, it shows on cnt_value within one tick: the counter either moves while it should hold or stalls while it should count. A missing or extra rearm pulse shows on the cycle right after the write that should or should not have caused it. A status register that has dropped or kept the wrong bit shows on irq_level, and in sts_clr one cycle after the clearing write. Mis-decoded offsets or lanes show as wrong read data on the very next response, or as a strobe on the wrong channel one cycle after the write.

// File: rtl/evt_pkg.sv
package evt_pkg;

    typedef enum logic [0:0] {CNT_HALT, CNT_RUN} cnt_state_e;

    typedef enum logic [2:0] {
        RG_NONE, RG_CAP, RG_CFG, RG_STS, RG_CNT, RG_CH_CFG, RG_CH_CMP, RG_CH_ROUTE
    } reg_sel_e;

    typedef struct packed {
        logic        ok;
        logic        wr;
        reg_sel_e    sel;
        logic [4:0]  chan;
        logic        narrow;
        logic        hi;
        logic [63:0] mask;
        logic [63:0] data;
    } acc_t;

    function automatic logic [63:0] lane_merge(input logic [63:0] old_v,
                                               input logic [63:0] data,
                                               input logic [63:0] mask);
        return (old_v & ~mask) | (data & mask);
    endfunction

endpackage

// File: rtl/evt_decode.sv
module evt_decode
    import evt_pkg::*;
#(
    parameter int N_CH   = 8,
    parameter int ADDR_W = 12
) (
    input  logic              valid,
    input  logic              write,
    input  logic [ADDR_W-1:0] addr,
    input  logic [3:0]        size,
    input  logic [63:0]       wdata,
    output acc_t              acc
);
    localparam int CH_BASE = 256;
    localparam int CH_SPAN = 32 * N_CH;

    logic [ADDR_W-1:0] qa;
    logic [ADDR_W-1:0] rel;
    logic              in_ch;

    always_comb begin
        qa    = {addr[ADDR_W-1:3], 3'b000};
        rel   = qa - ADDR_W'(CH_BASE);
        in_ch = (qa >= ADDR_W'(CH_BASE)) && (qa < ADDR_W'(CH_BASE + CH_SPAN));

        acc        = '0;
        acc.wr     = write;
        acc.narrow = (size == 4'd4);
        acc.hi     = (size == 4'd4) && addr[2];
        acc.ok     = valid && (((size == 4'd4) && (addr[1:0] == 2'b00)) ||
                               ((size == 4'd8) && (addr[2:0] == 3'b000)));
        if (!acc.narrow) begin
            acc.mask = '1;
            acc.data = wdata;
        end else if (acc.hi) begin
            acc.mask = {32'hFFFF_FFFF, 32'h0};
            acc.data = {wdata[31:0], 32'h0};
        end else begin
            acc.mask = {32'h0, 32'hFFFF_FFFF};
            acc.data = {32'h0, wdata[31:0]};
        end

        acc.sel = RG_NONE;
        if (in_ch) begin
            acc.chan = 5'(rel >> 5);
            unique case (rel[4:3])
                2'd0:    acc.sel = RG_CH_CFG;
                2'd1:    acc.sel = RG_CH_CMP;
                2'd2:    acc.sel = RG_CH_ROUTE;
                default: acc.sel = RG_NONE;
            endcase
        end else begin
            unique case (qa)
                ADDR_W'(12'h000): acc.sel = RG_CAP;
                ADDR_W'(12'h010): acc.sel = RG_CFG;
                ADDR_W'(12'h020): acc.sel = RG_STS;
                ADDR_W'(12'h0F0): acc.sel = RG_CNT;
                default:          acc.sel = RG_NONE;
            endcase
        end
    end
endmodule

// File: rtl/evt_counter.sv
module evt_counter
    import evt_pkg::*;
(
    input  logic        clk,
    input  logic        rst_n,
    input  logic        tick_en,
    input  logic        cfg_wr,
    input  logic        en_next,
    input  logic        cnt_wr,
    input  logic [63:0] wr_data,
    input  logic [63:0] wr_mask,
    output logic [31:0] cnt_q,
    output logic        running,
    output logic        rearm
);
    cnt_state_e  state_q, state_d;
    logic [63:0] merged;
    logic        start_go;

    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= CNT_HALT;
        else        state_q <= state_d;
    end

    always_comb begin
        state_d  = state_q;
        start_go = 1'b0;
        unique case (state_q)
            CNT_HALT: if (cfg_wr && en_next) begin
                state_d  = CNT_RUN;
                start_go = 1'b1;
            end
            CNT_RUN:  if (cfg_wr && !en_next) state_d = CNT_HALT;
            default:  state_d = CNT_HALT;
        endcase
    end

    assign merged = lane_merge({32'h0, cnt_q}, wr_data, wr_mask);

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt_q <= '0;
            rearm <= 1'b0;
        end else begin
            rearm <= start_go || (cnt_wr && (state_q == CNT_RUN));
            if (cnt_wr)
                cnt_q <= merged[31:0];
            else if ((state_q == CNT_RUN) && tick_en)
                cnt_q <= cnt_q + 32'd1;
        end
    end

    assign running = (state_q == CNT_RUN);

    a_r5_hold_when_halted: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == CNT_HALT && !cnt_wr) |=> (cnt_q == $past(cnt_q)));
    a_r6_tick_counts: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == CNT_RUN && tick_en && !cnt_wr) |=> (cnt_q == $past(cnt_q) + 32'd1));
    a_r7_rearm_only_running: assert property (@(posedge clk) disable iff (!rst_n)
        rearm |-> (state_q == CNT_RUN));
endmodule

// File: rtl/evt_status.sv
module evt_status #(
    parameter int N_CH = 8
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic [N_CH-1:0] lvl_set,
    input  logic            clr_wr,
    input  logic [N_CH-1:0] clr_bits,
    output logic [N_CH-1:0] isr_q,
    output logic [N_CH-1:0] sts_clr
);
    logic [N_CH-1:0] clr_now;

    assign clr_now = clr_wr ? (clr_bits & isr_q) : '0;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            isr_q   <= '0;
            sts_clr <= '0;
        end else begin
            isr_q   <= (isr_q & ~clr_now) | lvl_set;
            sts_clr <= clr_now;
        end
    end

    a_r8_clear_only_set: assert property (@(posedge clk) disable iff (!rst_n)
        (sts_clr & ~$past(isr_q)) == '0);
    a_r8_line_drops: assert property (@(posedge clk) disable iff (!rst_n)
        (sts_clr & isr_q & ~$past(lvl_set)) == '0);
endmodule

// File: rtl/evt_chan_bank.sv
module evt_chan_bank
    import evt_pkg::*;
#(
    parameter int N_CH = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  acc_t             acc,
    output logic [N_CH*64-1:0] chan_cfg,
    output logic [N_CH*32-1:0] chan_cmp,
    output logic [N_CH*64-1:0] chan_route,
    output logic [N_CH-1:0]  chan_wr_cfg,
    output logic [N_CH-1:0]  chan_wr_cmp,
    output logic [N_CH-1:0]  chan_wr_route,
    output logic [63:0]      rd_data
);
    for (genvar i = 0; i < N_CH; i++) begin : g_ch
        logic [63:0] cfg_q, route_q;
        logic [31:0] cmp_q;
        logic        s_cfg, s_cmp, s_route;
        logic        hit;
        logic [63:0] cmp_m;

        assign hit   = acc.ok && acc.wr && (acc.chan == 5'(i));
        assign cmp_m = lane_merge({32'h0, cmp_q}, acc.data, acc.mask);

        always_ff @(posedge clk) begin
            if (!rst_n) begin
                cfg_q   <= '0;
                cmp_q   <= 32'hFFFF_FFFF;
                route_q <= '0;
                s_cfg   <= 1'b0;
                s_cmp   <= 1'b0;
                s_route <= 1'b0;
            end else begin
                s_cfg   <= hit && (acc.sel == RG_CH_CFG);
                s_cmp   <= hit && (acc.sel == RG_CH_CMP);
                s_route <= hit && (acc.sel == RG_CH_ROUTE);
                if (hit && acc.sel == RG_CH_CFG)
                    cfg_q <= lane_merge(cfg_q, acc.data, acc.mask);
                if (hit && acc.sel == RG_CH_CMP)
                    cmp_q <= cmp_m[31:0];
                if (hit && acc.sel == RG_CH_ROUTE)
                    route_q <= lane_merge(route_q, acc.data, acc.mask);
            end
        end

        assign chan_cfg[i*64 +: 64]   = cfg_q;
        assign chan_cmp[i*32 +: 32]   = cmp_q;
        assign chan_route[i*64 +: 64] = route_q;
        assign chan_wr_cfg[i]         = s_cfg;
        assign chan_wr_cmp[i]         = s_cmp;
        assign chan_wr_route[i]       = s_route;
    end

    always_comb begin
        rd_data = '0;
        if (int'(acc.chan) < N_CH) begin
            unique case (acc.sel)
                RG_CH_CFG:   rd_data = chan_cfg[int'(acc.chan)*64 +: 64];
                RG_CH_CMP:   rd_data = {32'h0, chan_cmp[int'(acc.chan)*32 +: 32]};
                RG_CH_ROUTE: rd_data = chan_route[int'(acc.chan)*64 +: 64];
                default:     rd_data = '0;
            endcase
        end
    end

    a_r9_one_strobe: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({chan_wr_cfg, chan_wr_cmp, chan_wr_route}));
endmodule

// File: rtl/evt_timer_regs.sv
module evt_timer_regs
    import evt_pkg::*;
#(
    parameter int N_CH   = 8,
    parameter int ADDR_W = 12
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                tick_en,
    input  logic                req_valid,
    input  logic                req_write,
    input  logic [ADDR_W-1:0]   req_addr,
    input  logic [3:0]          req_size,
    input  logic [63:0]         req_wdata,
    output logic                rsp_valid,
    output logic [63:0]         rsp_rdata,
    output logic [31:0]         cnt_value,
    output logic                counting,
    output logic                rearm,
    input  logic [N_CH-1:0]     lvl_set,
    output logic [N_CH-1:0]     irq_level,
    output logic [N_CH-1:0]     sts_clr,
    output logic [N_CH*64-1:0]  chan_cfg,
    output logic [N_CH*32-1:0]  chan_cmp,
    output logic [N_CH*64-1:0]  chan_route,
    output logic [N_CH-1:0]     chan_wr_cfg,
    output logic [N_CH-1:0]     chan_wr_cmp,
    output logic [N_CH-1:0]     chan_wr_route
);
    localparam logic [63:0] CAP_WORD =
        {32'd59604644, 16'h8086, 3'b000, 5'(N_CH - 1), 8'h01};

    acc_t        acc;
    logic [63:0] cfg_q, cfg_next, ch_rd, full_rd, lane_rd;
    logic        wr_cfg, wr_cnt, wr_sts;

    evt_decode #(.N_CH(N_CH), .ADDR_W(ADDR_W)) u_dec (
        .valid(req_valid), .write(req_write), .addr(req_addr),
        .size(req_size), .wdata(req_wdata), .acc(acc)
    );

    assign wr_cfg   = acc.ok && acc.wr && (acc.sel == RG_CFG);
    assign wr_cnt   = acc.ok && acc.wr && (acc.sel == RG_CNT);
    assign wr_sts   = acc.ok && acc.wr && (acc.sel == RG_STS);
    assign cfg_next = lane_merge(cfg_q, acc.data, acc.mask) & ~64'h2;

    always_ff @(posedge clk) begin
        if (!rst_n)      cfg_q <= '0;
        else if (wr_cfg) cfg_q <= cfg_next;
    end

    evt_counter u_cnt (
        .clk(clk), .rst_n(rst_n), .tick_en(tick_en),
        .cfg_wr(wr_cfg), .en_next(cfg_next[0]),
        .cnt_wr(wr_cnt), .wr_data(acc.data), .wr_mask(acc.mask),
        .cnt_q(cnt_value), .running(counting), .rearm(rearm)
    );

    evt_status #(.N_CH(N_CH)) u_sts (
        .clk(clk), .rst_n(rst_n), .lvl_set(lvl_set),
        .clr_wr(wr_sts), .clr_bits(acc.data[N_CH-1:0] & acc.mask[N_CH-1:0]),
        .isr_q(irq_level), .sts_clr(sts_clr)
    );

    evt_chan_bank #(.N_CH(N_CH)) u_bank (
        .clk(clk), .rst_n(rst_n), .acc(acc),
        .chan_cfg(chan_cfg), .chan_cmp(chan_cmp), .chan_route(chan_route),
        .chan_wr_cfg(chan_wr_cfg), .chan_wr_cmp(chan_wr_cmp),
        .chan_wr_route(chan_wr_route), .rd_data(ch_rd)
    );

    always_comb begin
        unique case (acc.sel)
            RG_CAP:      full_rd = CAP_WORD;
            RG_CFG:      full_rd = cfg_q;
            RG_STS:      full_rd = 64'(irq_level);
            RG_CNT:      full_rd = {32'h0, cnt_value};
            RG_CH_CFG,
            RG_CH_CMP,
            RG_CH_ROUTE: full_rd = ch_rd;
            default:     full_rd = '0;
        endcase
        if (!acc.ok)         lane_rd = '0;
        else if (!acc.narrow) lane_rd = full_rd;
        else if (acc.hi)     lane_rd = {32'h0, full_rd[63:32]};
        else                 lane_rd = {32'h0, full_rd[31:0]};
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rsp_valid <= 1'b0;
            rsp_rdata <= '0;
        end else begin
            rsp_valid <= req_valid && !req_write;
            rsp_rdata <= (req_valid && !req_write) ? lane_rd : '0;
        end
    end

    a_r1_reject_no_effect: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && req_write && !acc.ok) |=>
        (!rearm && chan_wr_cfg == '0 && chan_wr_cmp == '0 && chan_wr_route == '0 && sts_clr == '0));
    a_r4_legacy_low: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && !req_write && acc.ok && acc.sel == RG_CFG && !acc.hi) |=> (rsp_rdata[1] == 1'b0));
    a_r11_rsp_follows_read: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_valid == $past(req_valid && !req_write));
endmodule

// File: tb/sim_evt_timer_regs.sv
module sim_evt_timer_regs;
    localparam int N = 8;

    logic clk = 1'b0, rst_n = 1'b0, tick_en = 1'b0;
    logic req_valid = 1'b0, req_write = 1'b0;
    logic [11:0] req_addr = '0;
    logic [3:0]  req_size = 4'd8;
    logic [63:0] req_wdata = '0;
    logic        rsp_valid, counting, rearm;
    logic [63:0] rsp_rdata;
    logic [31:0] cnt_value;
    logic [N-1:0] lvl_set = '0, irq_level, sts_clr, wcfg, wcmp, wroute;
    logic [N*64-1:0] ccfg, croute;
    logic [N*32-1:0] ccmp;

    int tests = 0, fails = 0;
    bit finished = 1'b0;
    logic [63:0] exp_q[$];
    string       tag_q[$];

    always #10 clk = ~clk;

    evt_timer_regs #(.N_CH(N), .ADDR_W(12)) u0 (
        .clk(clk), .rst_n(rst_n), .tick_en(tick_en),
        .req_valid(req_valid), .req_write(req_write), .req_addr(req_addr),
        .req_size(req_size), .req_wdata(req_wdata),
        .rsp_valid(rsp_valid), .rsp_rdata(rsp_rdata),
        .cnt_value(cnt_value), .counting(counting), .rearm(rearm),
        .lvl_set(lvl_set), .irq_level(irq_level), .sts_clr(sts_clr),
        .chan_cfg(ccfg), .chan_cmp(ccmp), .chan_route(croute),
        .chan_wr_cfg(wcfg), .chan_wr_cmp(wcmp), .chan_wr_route(wroute)
    );

    task automatic chk(input logic [63:0] act, input logic [63:0] exp, input string tag);
        tests++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s: actual 0x%0h expected 0x%0h", tag, act, exp);
        end
    endtask

    // scoreboard monitor
    always @(negedge clk) begin
        if (rst_n && rsp_valid) begin
            if (exp_q.size() == 0) begin
                chk(rsp_rdata, 64'hDEAD, "R11 unexpected response");
            end else begin
                logic [63:0] e;
                string t;
                e = exp_q.pop_front();
                t = tag_q.pop_front();
                chk(rsp_rdata, e, t);
            end
        end
    end

    task automatic rd(input logic [11:0] a, input logic [3:0] s, input logic [63:0] e, input string t);
        req_valid = 1'b1; req_write = 1'b0; req_addr = a; req_size = s;
        exp_q.push_back(e); tag_q.push_back(t);
        @(negedge clk);
        req_valid = 1'b0;
    endtask

    task automatic wr(input logic [11:0] a, input logic [3:0] s, input logic [63:0] d);
        req_valid = 1'b1; req_write = 1'b1; req_addr = a; req_size = s; req_wdata = d;
        @(negedge clk);
        req_valid = 1'b0; req_write = 1'b0;
    endtask

    task automatic ticks(input int n);
        tick_en = 1'b1;
        repeat (n) @(negedge clk);
        tick_en = 1'b0;
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // reset state
        chk(cnt_value, 0, "R5 reset counter");
        chk(counting, 0, "R5 reset halted");
        chk(irq_level, 0, "R8 reset status");
        chk(ccmp[31:0], 32'hFFFF_FFFF, "R9 reset comparator");
        // capability and lanes
        rd(12'h000, 4'd8, 64'h038D7EA4_80860701, "R3 capability 8B");
        rd(12'h004, 4'd4, 64'h038D7EA4, "R2 R3 capability upper lane");
        rd(12'h000, 4'd4, 64'h80860701, "R2 R3 capability lower lane");
        // illegal and unmapped
        rd(12'h000, 4'd2, 0, "R1 size 2 read");
        rd(12'h004, 4'd8, 0, "R1 misaligned 8B read");
        rd(12'h002, 4'd4, 0, "R1 misaligned 4B read");
        rd(12'h030, 4'd8, 0, "R10 unmapped 0x030");
        rd(12'h118, 4'd8, 0, "R10 unmapped channel slot");
        rd(12'h200, 4'd8, 0, "R10 beyond last channel");
        // start counting
        wr(12'h010, 4'd8, 64'h3);
        chk(counting, 1, "R4 R6 START");
        chk(rearm, 1, "R7 rearm on START");
        rd(12'h010, 4'd8, 64'h1, "R4 legacy bit reads 0");
        chk(rearm, 0, "R7 rearm single pulse");
        ticks(5);
        chk(cnt_value, 5, "R6 five ticks");
        rd(12'h0F0, 4'd8, 64'h5, "R7 R11 counter read");
        wr(12'h014, 4'd4, 64'hF);
        chk(counting, 1, "R2 upper config write keeps enable");
        rd(12'h010, 4'd8, 64'h0000000F_00000001, "R2 upper lane write");
        wr(12'h010, 4'd4, 64'h0);
        chk(counting, 0, "R4 STOP");
        rd(12'h010, 4'd8, 64'h0000000F_00000000, "R2 lower lane write");
        ticks(3);
        chk(cnt_value, 5, "R5 hold while halted");
        wr(12'h0F4, 4'd4, 64'h1234);
        chk(cnt_value, 5, "R7 upper counter write ignored");
        wr(12'h0F0, 4'd4, 64'd100);
        chk(cnt_value, 100, "R7 counter write");
        chk(rearm, 0, "R7 no rearm when halted");
        wr(12'h010, 4'd4, 64'h1);
        chk(rearm, 1, "R7 rearm on restart");
        ticks(2);
        chk(cnt_value, 102, "R6 resume from held value");
        wr(12'h0F0, 4'd8, 64'hFFFF_FFFF);
        chk(rearm, 1, "R7 rearm on counter write while running");
        ticks(1);
        chk(cnt_value, 0, "R6 wrap");
        wr(12'h010, 4'd2, 64'h0);
        chk(counting, 1, "R1 illegal config write ignored");
        // status
        lvl_set = 8'b0000_0101;
        @(negedge clk);
        lvl_set = '0;
        chk(irq_level, 8'h05, "R8 set");
        wr(12'h020, 4'd8, 64'h6);
        chk(sts_clr, 8'h04, "R8 clear request only set bits");
        chk(irq_level, 8'h01, "R8 line drops");
        rd(12'h020, 4'd8, 64'h1, "R8 status read");
        chk(sts_clr, 8'h00, "R8 clear single pulse");
        // channels
        wr(12'h148, 4'd8, 64'h55);
        chk(wcmp, 8'h04, "R9 comparator strobe ch2");
        chk(ccmp[2*32 +: 32], 32'h55, "R9 comparator bus ch2");
        rd(12'h148, 4'd8, 64'h55, "R9 comparator read");
        wr(12'h124, 4'd4, 64'hAABB);
        chk(wcfg, 8'h02, "R9 config strobe ch1");
        rd(12'h120, 4'd8, 64'h0000AABB_00000000, "R2 R9 channel config upper");
        wr(12'h1F0, 4'd8, 64'h12345678_9ABCDEF0);
        chk(wroute, 8'h80, "R9 route strobe ch7");
        rd(12'h1F4, 4'd4, 64'h12345678, "R9 route upper read");
        wr(12'h14C, 4'd8, 64'h99);
        chk(wcmp, 8'h00, "R1 misaligned write no strobe");
        rd(12'h148, 4'd8, 64'h55, "R1 misaligned write no change");
        repeat (3) @(negedge clk);
        chk(exp_q.size(), 0, "R11 all responses seen");
        if (!finished) begin
            finished = 1'b1;
            $display("[TB] %0d tests run, %0d failed", tests, fails);
            $finish;
        end
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!finished) begin
            finished = 1'b1;
            tests++; fails++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("[TB] %0d tests run, %0d failed", tests, fails);
            $finish;
        end
    end
endmodule